// File: doc/BRIEF.md
# Load-Use Hazard Detector and Stall Control

This block sits beside the decode stage of an in-order five-stage pipeline. Each cycle it compares the two source register IDs of the instruction in decode with the register that the instruction in execute will fill from memory. A hazard exists when the execute-stage instruction is a load, meaning a memory-to-register move or a pop, and its memory destination is one of those sources. In that case the loaded value will not exist until the memory stage reads it, so it cannot be forwarded in time.

On a hazard the block holds the PC register and the decode register for one clock edge. It also turns the execute register into a bubble, so that a no-op with "no register" destinations enters execute in place of the consumer. On the following cycle the load has moved on to memory and the bubble sits in execute, so the hazard clears. The consumer, now decoded a second time, picks up the loaded word through forwarding from the memory stage's read data. ALU results never cause a stall, because forwarding already covers them.

Top module: `lu_hazard_ctl`

## Requirements
- R1: When the execute opcode is the load code (4'h5), the memory destination is not the no-register code (4'hF), and it equals the decode source A, `pc_hold`, `dec_hold` and `ex_squash` are all 1 in the same cycle.
- R2: When the execute opcode is the pop code (4'hB) and its memory destination (not 4'hF) equals decode source B, all three control outputs are 1.
- R3: With a load or pop in execute whose destination matches neither decode source, all three outputs are 0.
- R4: Any execute opcode other than 4'h5 or 4'hB, including ALU and no-op (4'h1) codes, drives all three outputs to 0, even when the destination ID equals a source.
- R5: A memory destination of 4'hF never raises any output, even when a decode source is also 4'hF.
- R6: The outputs are combinational and follow the inputs within the same cycle, so that they take effect at the next rising edge.
- R7: `pc_hold`, `dec_hold` and `ex_squash` are always equal to one another.
- R8: Once a bubble (opcode 4'h1, destination 4'hF) reaches execute after a hazard, the outputs return to 0, so each hazard costs exactly one stall cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only by the embedded checks |
| rst_n | input | 1 | Active-low reset, used only to disable the embedded checks |
| ex_op | input | OPW | Opcode of the instruction in execute |
| ex_mdst | input | RW | Memory destination register ID of the instruction in execute |
| dec_ra | input | RW | First source register ID of the instruction in decode |
| dec_rb | input | RW | Second source register ID of the instruction in decode |
| pc_hold | output | 1 | Keep the PC register unchanged at the next edge |
| dec_hold | output | 1 | Keep the decode register unchanged at the next edge |
| ex_squash | output | 1 | Load a no-op with no-register destinations into execute at the next edge |

## Verification
The one-cycle check assumes the surrounding pipeline obeys the squash. The cycle after a hazard, execute must hold the bubble's no-op opcode and no-register destination. The random stimulus respects this by tracking the expected hazard and driving that bubble on the next cycle. Every other cycle draws opcodes and register IDs freely, with the register IDs skewed so that matches and no-register codes come up often.

// File: rtl/lu_hazard_ctl.sv
module lu_hazard_ctl #(
  parameter int OPW = 4,
  parameter int RW = 4,
  parameter logic [OPW-1:0] OP_LOAD = 4'h5,
  parameter logic [OPW-1:0] OP_POP = 4'hB,
  parameter logic [OPW-1:0] OP_NOP = 4'h1,
  parameter logic [RW-1:0] NO_REG = 4'hF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] ex_op,
  input  logic [RW-1:0]  ex_mdst,
  input  logic [RW-1:0]  dec_ra,
  input  logic [RW-1:0]  dec_rb,
  output logic           pc_hold,
  output logic           dec_hold,
  output logic           ex_squash
);

  logic is_load, dst_live, src_hit, hazard;

  assign is_load  = (ex_op == OP_LOAD) || (ex_op == OP_POP);
  assign dst_live = (ex_mdst != NO_REG);
  assign src_hit  = (ex_mdst == dec_ra) || (ex_mdst == dec_rb);
  assign hazard   = is_load && dst_live && src_hit;

  assign pc_hold   = hazard;
  assign dec_hold  = hazard;
  assign ex_squash = hazard;

  // R1 R2: a live load destination matching a source must stall
  p_load_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((ex_op == OP_LOAD || ex_op == OP_POP) && ex_mdst != NO_REG &&
     (ex_mdst == dec_ra || ex_mdst == dec_rb)) |-> (pc_hold && dec_hold));

  p_non_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_op != OP_LOAD && ex_op != OP_POP) |-> !(pc_hold || dec_hold || ex_squash));

  p_no_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mdst == NO_REG) |-> !(pc_hold || dec_hold || ex_squash));

  p_outputs_agree_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ex_squash |-> (pc_hold && dec_hold));

  // R8: relies on upstream loading the bubble after a squash
  p_single_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ex_squash |=> !ex_squash);

endmodule

// File: tb/lu_hazard_ctl_bench.sv
module lu_hazard_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] ex_op = 4'h1, ex_mdst = 4'hF, dec_ra = 4'hF, dec_rb = 4'hF;
  logic pc_hold, dec_hold, ex_squash;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lu_hazard_ctl u_lu_hazard_ctl (
    .clk(clk), .rst_n(rst_n), .ex_op(ex_op), .ex_mdst(ex_mdst),
    .dec_ra(dec_ra), .dec_rb(dec_rb),
    .pc_hold(pc_hold), .dec_hold(dec_hold), .ex_squash(ex_squash)
  );

  function automatic bit want(input logic [3:0] op, d, a, b);
    return (op == 4'h5 || op == 4'hB) && d != 4'hF && (d == a || d == b);
  endfunction

  task automatic check(input string req);
    bit e;
    e = want(ex_op, ex_mdst, dec_ra, dec_rb);
    total++;
    if (pc_hold !== e || dec_hold !== e || ex_squash !== e) begin
      bad++;
      $display("FAIL %s: op=%h d=%h a=%h b=%h got=%b%b%b exp=%b%b%b", req, ex_op,
               ex_mdst, dec_ra, dec_rb, pc_hold, dec_hold, ex_squash, e, e, e);
    end
  endtask

  task automatic apply(input logic [3:0] op, d, a, b, input string req);
    @(posedge clk); #1;
    ex_op = op; ex_mdst = d; dec_ra = a; dec_rb = b;
    #3 check(req);
  endtask

  function automatic logic [3:0] pick_reg();
    int r = $urandom_range(0, 9);
    if (r < 2) return 4'hF;
    return 4'($urandom_range(0, 3));
  endfunction

  initial begin
    void'($urandom(32'd1234));
    #2 check("R6 reset state");
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    apply(4'h5, 4'h2, 4'h2, 4'h7, "R1 load hits A");
    apply(4'h1, 4'hF, 4'h2, 4'h7, "R8 bubble clears");
    apply(4'hB, 4'h4, 4'h0, 4'h4, "R2 pop hits B");
    apply(4'h1, 4'hF, 4'h0, 4'h4, "R8 bubble clears");
    apply(4'h5, 4'h3, 4'h1, 4'h2, "R3 load misses");
    apply(4'hB, 4'h6, 4'h5, 4'h5, "R3 pop misses");
    apply(4'h6, 4'h2, 4'h2, 4'h2, "R4 ALU op matching ids");
    apply(4'h2, 4'h3, 4'h3, 4'h0, "R4 move op matching id");
    apply(4'h5, 4'hF, 4'hF, 4'hF, "R5 load no-reg dst");
    apply(4'hB, 4'hF, 4'h1, 4'hF, "R5 pop no-reg dst");
    apply(4'h5, 4'h1, 4'h1, 4'h1, "R7 both sources hit");
    apply(4'h1, 4'hF, 4'h1, 4'h1, "R8 bubble clears");
    for (int i = 0; i < 3000; i++) begin
      if (want(ex_op, ex_mdst, dec_ra, dec_rb))
        apply(4'h1, 4'hF, dec_ra, dec_rb, "R8 random bubble");
      else begin
        logic [3:0] op;
        int s = $urandom_range(0, 3);
        op = (s == 0) ? 4'h5 : (s == 1) ? 4'hB : 4'($urandom_range(0, 15));
        apply(op, pick_reg(), pick_reg(), pick_reg(), "R1 R2 R3 R4 R5 random");
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=timeout exp=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule